// File: doc/BRIEF.md
# CAN Wakeup Frame Matcher

This block sits after a CAN receive engine and screens each fully received frame against a static wakeup filter. When a frame passes, it either requests a wakeup at once or counts the frame toward a programmed number of passing frames. A received frame arrives as a one-cycle valid strobe. The strobe carries the frame's format bit (IDE), remote bit (RTR), identifier, DLC and eight data bytes. The filter is held on configuration inputs: a frame filter type, an identifier comparison mode, expected values with masks or bounds, a DLC window, a data pattern with a byte mask, and a required frame count.

The frame filter type selects one of two checks. The header check covers IDE, RTR and identifier. The full check adds the DLC window and the data pattern to the header check. The type also selects whether a single passing frame is enough or a number of passing frames is needed. The identifier can be tested by masked equality, as a lower bound, as an upper bound, or against an inclusive range. A small state machine turns a passing frame into a one-cycle wakeup pulse and a sticky wakeup flag. It has three states. ST_ARMED counts passing frames. ST_FIRE lasts one cycle and drives the pulse. ST_DONE holds the flag and ignores further frames. Its transitions are as follows. From ST_ARMED it goes to ST_FIRE when a passing frame brings the count to the target. From ST_FIRE it always goes to ST_DONE. A software clear takes it from any state back to ST_ARMED with the count at zero. Reset does the same.

Top module: `canwk_matcher`

## Requirements
- R1: Filter type 0 gives a wakeup on one frame that passes the header check. DLC and data have no effect in this type.
- R2: Filter type 1 gives a wakeup on one frame that passes both the header check and the DLC and data checks.
- R3: Filter type 2 counts frames that pass the header check. It gives a wakeup on the frame that brings the count to cfg_need. Frames that fail are not counted.
- R4: Filter type 3 counts frames that pass the full check. It gives a wakeup when that count reaches cfg_need.
- R5: IDE is compared only when cfg_ide_msk is 1, and RTR only when cfg_rtr_msk is 1. A clear mask bit makes that bit a don't-care.
- R6: ID mode 0 passes when every identifier bit set in cfg_id_aux is equal in the received ID and in cfg_id.
- R7: ID mode 1 passes when the received ID is at least cfg_id. ID mode 2 passes when it is at most cfg_id. cfg_id_aux has no effect in modes 1 and 2.
- R8: ID mode 3 passes when cfg_id <= ID <= cfg_id_aux, with both bounds included.
- R9: With rx_ide=1 all 29 identifier bits take part in the comparison. With rx_ide=0 only bits 10:0 of the received ID, cfg_id and cfg_id_aux take part.
- R10: The DLC check passes when cfg_dlc_lo <= rx_dlc <= cfg_dlc_hi.
- R11: Data byte i occupies bits 8i+7:8i. Byte i is checked, under the mask bits in the same positions of cfg_data_msk, only when i < min(rx_dlc, 8). Bytes beyond that limit are ignored.
- R12: A cfg_need of 0 acts as 1.
- R13: wake_pulse is high for exactly one cycle, in the cycle after the strobe of the deciding frame. wake_flag rises with it and stays high. Later frames give no pulse. Reset or sw_clr drops the flag and zeroes the count.
- R14: Without frame_vld no frame is evaluated. The fields alone cause no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_clr | input | 1 | Clears the count and the wakeup flag |
| frame_vld | input | 1 | One-cycle strobe for a received frame |
| rx_ide | input | 1 | Received format bit (1 = extended) |
| rx_rtr | input | 1 | Received remote bit |
| rx_id | input | 29 | Received identifier, standard IDs right-aligned |
| rx_dlc | input | 4 | Received DLC |
| rx_data | input | 64 | Received data, byte i at bits 8i+7:8i |
| cfg_ftype | input | 2 | Frame filter type 0..3 |
| cfg_idmode | input | 2 | ID mode: 0 masked, 1 at least, 2 at most, 3 range |
| cfg_ide | input | 1 | Expected IDE |
| cfg_ide_msk | input | 1 | Enables the IDE comparison |
| cfg_rtr | input | 1 | Expected RTR |
| cfg_rtr_msk | input | 1 | Enables the RTR comparison |
| cfg_id | input | 29 | Expected ID, or lower bound |
| cfg_id_aux | input | 29 | ID mask in mode 0, upper bound in mode 3 |
| cfg_dlc_lo | input | 4 | Lowest accepted DLC |
| cfg_dlc_hi | input | 4 | Highest accepted DLC |
| cfg_data | input | 64 | Expected data bytes |
| cfg_data_msk | input | 64 | Data compare mask |
| cfg_need | input | 8 | Passing frames required in the counting types |
| wake_pulse | output | 1 | One-cycle wakeup event |
| wake_flag | output | 1 | Sticky wakeup status |

## Verification
The filter decision is combinational, and a single register sits behind it: the state register. The pulse for a deciding frame is therefore high during the cycle that follows the clock edge that sampled frame_vld, and the flag rises at that same edge. Inputs are driven on the falling edge and each strobe spans one rising edge. Pulse and flag are read on the next falling edge, the midpoint of the only cycle in which the pulse may be high. Each non-pulse and each count is checked frame by frame at that same point.

// File: rtl/canwk_pkg.sv
package canwk_pkg;
    typedef enum logic [1:0] {
        FT_ONE_HDR = 2'd0,
        FT_ONE_ALL = 2'd1,
        FT_CNT_HDR = 2'd2,
        FT_CNT_ALL = 2'd3
    } ftype_e;

    typedef enum logic [1:0] {
        IDM_MASK  = 2'd0,
        IDM_GE    = 2'd1,
        IDM_LE    = 2'd2,
        IDM_RANGE = 2'd3
    } idmode_e;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_FIRE  = 2'd1,
        ST_DONE  = 2'd2
    } wk_state_e;
endpackage

// File: rtl/canwk_id_cmp.sv
module canwk_id_cmp #(
    parameter int ID_W  = 29,
    parameter int STD_W = 11
) (
    input  logic [1:0]      mode,
    input  logic            ext,
    input  logic [ID_W-1:0] rx_id,
    input  logic [ID_W-1:0] lo_id,
    input  logic [ID_W-1:0] aux_id,
    output logic            hit
);
    import canwk_pkg::*;
    localparam int PAD_W = ID_W - STD_W;

    logic [ID_W-1:0] width_msk, rx_e, lo_e, aux_e;

    // standard frames compare only the low identifier bits
    assign width_msk = ext ? {ID_W{1'b1}} : {{PAD_W{1'b0}}, {STD_W{1'b1}}};
    assign rx_e  = rx_id  & width_msk;
    assign lo_e  = lo_id  & width_msk;
    assign aux_e = aux_id & width_msk;

    always_comb begin
        unique case (idmode_e'(mode))
            IDM_MASK:  hit = ((rx_e ^ lo_e) & aux_e) == '0;
            IDM_GE:    hit = rx_e >= lo_e;
            IDM_LE:    hit = rx_e <= lo_e;
            IDM_RANGE: hit = (rx_e >= lo_e) && (rx_e <= aux_e);
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/canwk_data_cmp.sv
module canwk_data_cmp #(
    parameter int NBYTES = 8,
    parameter int DLC_W  = 4
) (
    input  logic [DLC_W-1:0]    dlc,
    input  logic [8*NBYTES-1:0] rx_data,
    input  logic [8*NBYTES-1:0] exp_data,
    input  logic [8*NBYTES-1:0] msk_data,
    output logic                hit
);
    localparam int                LEN_W = $clog2(NBYTES + 1);
    localparam logic [DLC_W-1:0]  NB_D  = DLC_W'(NBYTES);

    logic [LEN_W-1:0]  len;
    logic [NBYTES-1:0] byte_ok;

    // DLC codes above the byte count still carry NBYTES bytes
    assign len = (dlc > NB_D) ? LEN_W'(NBYTES) : LEN_W'(dlc);

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign byte_ok[g] = (LEN_W'(g) >= len) ||
            (((rx_data[8*g +: 8] ^ exp_data[8*g +: 8]) & msk_data[8*g +: 8]) == 8'h00);
    end

    assign hit = &byte_ok;
endmodule

// File: rtl/canwk_count_fsm.sv
module canwk_count_fsm #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hit,
    input  logic             counting,
    input  logic [CNT_W-1:0] need,
    output logic             pulse,
    output logic             flag
);
    import canwk_pkg::*;

    wk_state_e        state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt, target;
    logic [CNT_W:0]   cnt_inc;

    assign target  = (!counting || need == '0) ? CNT_W'(1) : need;
    assign cnt_inc = {1'b0, cnt} + 1'b1;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        if (clr) begin
            state_nxt = ST_ARMED;
            cnt_nxt   = '0;
        end else begin
            unique case (state)
                ST_ARMED: if (hit) begin
                    if (cnt_inc >= {1'b0, target}) begin
                        state_nxt = ST_FIRE;
                        cnt_nxt   = target;
                    end else begin
                        cnt_nxt = cnt_inc[CNT_W-1:0];
                    end
                end
                ST_FIRE:  state_nxt = ST_DONE;
                ST_DONE:  state_nxt = ST_DONE;
                default:  state_nxt = ST_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ARMED;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        pulse = (state == ST_FIRE);
        flag  = (state == ST_FIRE) || (state == ST_DONE);
    end

    AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R13
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag); // R13
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state == ST_ARMED) && (cnt == '0)); // R13
    AST_PULSE_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(hit)); // R14
endmodule

// File: rtl/canwk_matcher.sv
module canwk_matcher #(
    parameter int ID_W   = 29,
    parameter int STD_W  = 11,
    parameter int DLC_W  = 4,
    parameter int NBYTES = 8,
    parameter int CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_clr,
    input  logic                frame_vld,
    input  logic                rx_ide,
    input  logic                rx_rtr,
    input  logic [ID_W-1:0]     rx_id,
    input  logic [DLC_W-1:0]    rx_dlc,
    input  logic [8*NBYTES-1:0] rx_data,
    input  logic [1:0]          cfg_ftype,
    input  logic [1:0]          cfg_idmode,
    input  logic                cfg_ide,
    input  logic                cfg_ide_msk,
    input  logic                cfg_rtr,
    input  logic                cfg_rtr_msk,
    input  logic [ID_W-1:0]     cfg_id,
    input  logic [ID_W-1:0]     cfg_id_aux,
    input  logic [DLC_W-1:0]    cfg_dlc_lo,
    input  logic [DLC_W-1:0]    cfg_dlc_hi,
    input  logic [8*NBYTES-1:0] cfg_data,
    input  logic [8*NBYTES-1:0] cfg_data_msk,
    input  logic [CNT_W-1:0]    cfg_need,
    output logic                wake_pulse,
    output logic                wake_flag
);
    import canwk_pkg::*;

    logic id_ok, data_ok, ide_ok, rtr_ok, dlc_ok;
    logic hdr_ok, all_ok, frame_hit;
    ftype_e ftype;

    assign ftype = ftype_e'(cfg_ftype);

    canwk_id_cmp #(.ID_W(ID_W), .STD_W(STD_W)) i_id_cmp (
        .mode   (cfg_idmode),
        .ext    (rx_ide),
        .rx_id  (rx_id),
        .lo_id  (cfg_id),
        .aux_id (cfg_id_aux),
        .hit    (id_ok)
    );

    canwk_data_cmp #(.NBYTES(NBYTES), .DLC_W(DLC_W)) i_data_cmp (
        .dlc      (rx_dlc),
        .rx_data  (rx_data),
        .exp_data (cfg_data),
        .msk_data (cfg_data_msk),
        .hit      (data_ok)
    );

    assign ide_ok = !(cfg_ide_msk && (rx_ide != cfg_ide));
    assign rtr_ok = !(cfg_rtr_msk && (rx_rtr != cfg_rtr));
    assign dlc_ok = (rx_dlc >= cfg_dlc_lo) && (rx_dlc <= cfg_dlc_hi);

    assign hdr_ok = ide_ok && rtr_ok && id_ok;
    assign all_ok = hdr_ok && dlc_ok && data_ok;

    always_comb begin
        unique case (ftype)
            FT_ONE_HDR, FT_CNT_HDR: frame_hit = frame_vld && hdr_ok;
            FT_ONE_ALL, FT_CNT_ALL: frame_hit = frame_vld && all_ok;
            default:                frame_hit = 1'b0;
        endcase
    end

    canwk_count_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sw_clr),
        .hit      (frame_hit),
        .counting (cfg_ftype[1]),
        .need     (cfg_need),
        .pulse    (wake_pulse),
        .flag     (wake_flag)
    );

    AST_FULL_NEEDS_DLC: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse && $past(cfg_ftype) == 2'd1 |->
        $past(frame_vld && rx_dlc >= cfg_dlc_lo && rx_dlc <= cfg_dlc_hi)); // R2
    AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_pulse) |-> $past(frame_vld)); // R14
endmodule

// File: tb/test_canwk_matcher.sv
`timescale 1ns/1ps
module test_canwk_matcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_clr = 1'b0;
    logic        frame_vld = 1'b0;
    logic        rx_ide = 1'b0, rx_rtr = 1'b0;
    logic [28:0] rx_id = '0;
    logic [3:0]  rx_dlc = '0;
    logic [63:0] rx_data = '0;
    logic [1:0]  cfg_ftype = '0, cfg_idmode = '0;
    logic        cfg_ide = 1'b0, cfg_ide_msk = 1'b0, cfg_rtr = 1'b0, cfg_rtr_msk = 1'b0;
    logic [28:0] cfg_id = '0, cfg_id_aux = '0;
    logic [3:0]  cfg_dlc_lo = '0, cfg_dlc_hi = '0;
    logic [63:0] cfg_data = '0, cfg_data_msk = '0;
    logic [7:0]  cfg_need = '0;
    logic        wake_pulse, wake_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit reported = 1'b0;

    always #2.5 clk = ~clk;

    canwk_matcher i_canwk_matcher (
        .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr), .frame_vld(frame_vld),
        .rx_ide(rx_ide), .rx_rtr(rx_rtr), .rx_id(rx_id), .rx_dlc(rx_dlc),
        .rx_data(rx_data), .cfg_ftype(cfg_ftype), .cfg_idmode(cfg_idmode),
        .cfg_ide(cfg_ide), .cfg_ide_msk(cfg_ide_msk), .cfg_rtr(cfg_rtr),
        .cfg_rtr_msk(cfg_rtr_msk), .cfg_id(cfg_id), .cfg_id_aux(cfg_id_aux),
        .cfg_dlc_lo(cfg_dlc_lo), .cfg_dlc_hi(cfg_dlc_hi), .cfg_data(cfg_data),
        .cfg_data_msk(cfg_data_msk), .cfg_need(cfg_need),
        .wake_pulse(wake_pulse), .wake_flag(wake_flag)
    );

    localparam logic [63:0] DGOOD = 64'h0000_5500_0000_BBAA;

    typedef struct packed {
        logic [1:0]  idm;
        logic        ide;
        logic [28:0] id;
        logic [28:0] lo;
        logic [28:0] aux;
        logic [3:0]  dlc;
        logic [63:0] data;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 29'h1ABCDE00, 29'h1ABCDE00, 29'h1FFFFFFF, 4'd4, DGOOD, 1'b1, 4'd6},  // R6
        '{2'd0, 1'b1, 29'h1ABCDE01, 29'h1ABCDE00, 29'h1FFFFFFF, 4'd4, DGOOD, 1'b0, 4'd6},  // R6
        '{2'd0, 1'b1, 29'h1ABCDE0F, 29'h1ABCDE00, 29'h1FFFFFF0, 4'd4, DGOOD, 1'b1, 4'd6},  // R6
        '{2'd1, 1'b1, 29'h100,      29'h100,      29'h0,        4'd4, DGOOD, 1'b1, 4'd7},  // R7
        '{2'd1, 1'b1, 29'h0FF,      29'h100,      29'h0,        4'd4, DGOOD, 1'b0, 4'd7},  // R7
        '{2'd2, 1'b1, 29'h100,      29'h100,      29'h0,        4'd4, DGOOD, 1'b1, 4'd7},  // R7
        '{2'd2, 1'b1, 29'h101,      29'h100,      29'h0,        4'd4, DGOOD, 1'b0, 4'd7},  // R7
        '{2'd3, 1'b1, 29'h200,      29'h100,      29'h300,      4'd4, DGOOD, 1'b1, 4'd8},  // R8
        '{2'd3, 1'b1, 29'h300,      29'h100,      29'h300,      4'd4, DGOOD, 1'b1, 4'd8},  // R8
        '{2'd3, 1'b1, 29'h301,      29'h100,      29'h300,      4'd4, DGOOD, 1'b0, 4'd8},  // R8
        '{2'd3, 1'b1, 29'h0FF,      29'h100,      29'h300,      4'd4, DGOOD, 1'b0, 4'd8},  // R8
        '{2'd0, 1'b0, 29'h1FFFF123, 29'h123,      29'h1FFFFFFF, 4'd4, DGOOD, 1'b1, 4'd9},  // R9
        '{2'd1, 1'b0, 29'h10000005, 29'h100,      29'h0,        4'd4, DGOOD, 1'b0, 4'd9},  // R9
        '{2'd2, 1'b0, 29'h10000005, 29'h100,      29'h0,        4'd4, DGOOD, 1'b1, 4'd9},  // R9
        '{2'd0, 1'b1, 29'h55,       29'h55,       29'h1FFFFFFF, 4'd1, DGOOD, 1'b0, 4'd10}, // R10
        '{2'd0, 1'b1, 29'h55,       29'h55,       29'h1FFFFFFF, 4'd2, DGOOD, 1'b1, 4'd10}, // R10
        '{2'd0, 1'b1, 29'h55,       29'h55,       29'h1FFFFFFF, 4'd6, DGOOD, 1'b1, 4'd10}, // R10
        '{2'd0, 1'b1, 29'h55,       29'h55,       29'h1FFFFFFF, 4'd7, DGOOD, 1'b0, 4'd10}, // R10
        '{2'd0, 1'b1, 29'h55,       29'h55,       29'h1FFFFFFF, 4'd4, 64'h0000_0000_0000_BBAA, 1'b1, 4'd11}, // R11
        '{2'd0, 1'b1, 29'h55,       29'h55,       29'h1FFFFFFF, 4'd6, 64'h0000_0000_0000_BBAA, 1'b0, 4'd11}, // R11
        '{2'd0, 1'b1, 29'h55,       29'h55,       29'h1FFFFFFF, 4'd4, 64'h0000_5500_0000_BCAA, 1'b0, 4'd11}, // R11
        '{2'd0, 1'b1, 29'h55,       29'h55,       29'h1FFFFFFF, 4'd4, 64'h0000_5500_00CC_BBAA, 1'b1, 4'd11}  // R11
    };

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    task automatic cfg_default();
        cfg_ftype = 2'd1; cfg_idmode = 2'd0;
        cfg_ide = 1'b1; cfg_ide_msk = 1'b0; cfg_rtr = 1'b0; cfg_rtr_msk = 1'b0;
        cfg_id = 29'h55; cfg_id_aux = 29'h1FFFFFFF;
        cfg_dlc_lo = 4'd2; cfg_dlc_hi = 4'd6;
        cfg_data = DGOOD; cfg_data_msk = 64'h0000_FF00_0000_FFFF;
        cfg_need = 8'd1;
    endtask

    task automatic clear();
        @(negedge clk); sw_clr = 1'b1;
        @(negedge clk); sw_clr = 1'b0;
    endtask

    // strobe spans one rising edge; pulse is read at the following falling edge
    task automatic send(input logic ide, input logic rtr, input logic [28:0] id,
                        input logic [3:0] dlc, input logic [63:0] data, output logic p);
        @(negedge clk);
        rx_ide = ide; rx_rtr = rtr; rx_id = id; rx_dlc = dlc; rx_data = data;
        frame_vld = 1'b1;
        @(negedge clk);
        frame_vld = 1'b0;
        p = wake_pulse;
    endtask

    task automatic good(output logic p);
        send(1'b1, 1'b0, 29'h55, 4'd4, DGOOD, p);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic p;
        cfg_default();
        repeat (3) @(negedge clk);
        chk("R13 reset pulse", wake_pulse, 1'b0);
        chk("R13 reset flag", wake_flag, 1'b0);
        rst_n = 1'b1;

        // table: single full-check frames
        for (int i = 0; i < NV; i++) begin
            cfg_default();
            clear();
            cfg_idmode = VECS[i].idm;
            cfg_id = VECS[i].lo;
            cfg_id_aux = VECS[i].aux;
            send(VECS[i].ide, 1'b0, VECS[i].id, VECS[i].dlc, VECS[i].data, p);
            chk($sformatf("R%0d row %0d", VECS[i].req, i), p, VECS[i].exp);
        end

        // R1: header-only ignores bad DLC and data
        cfg_default(); clear(); cfg_ftype = 2'd0;
        send(1'b1, 1'b0, 29'h55, 4'd0, 64'h0, p);
        chk("R1 header only", p, 1'b1);
        cfg_default(); clear();
        send(1'b1, 1'b0, 29'h55, 4'd0, 64'h0, p);
        chk("R2 full check rejects DLC", p, 1'b0);

        // R14: fields present without strobe
        cfg_default(); clear();
        @(negedge clk);
        rx_ide = 1'b1; rx_rtr = 1'b0; rx_id = 29'h55; rx_dlc = 4'd4; rx_data = DGOOD;
        repeat (3) @(negedge clk);
        chk("R14 no strobe pulse", wake_pulse, 1'b0);
        chk("R14 no strobe flag", wake_flag, 1'b0);

        // R5: IDE and RTR masks
        cfg_default(); clear(); cfg_ftype = 2'd0; cfg_ide_msk = 1'b1;
        send(1'b0, 1'b0, 29'h55, 4'd4, DGOOD, p);
        chk("R5 IDE compared", p, 1'b0);
        clear(); cfg_ide_msk = 1'b0;
        send(1'b0, 1'b0, 29'h55, 4'd4, DGOOD, p);
        chk("R5 IDE masked", p, 1'b1);
        clear(); cfg_rtr_msk = 1'b1;
        send(1'b1, 1'b1, 29'h55, 4'd4, DGOOD, p);
        chk("R5 RTR compared", p, 1'b0);

        // R3: header count of three
        cfg_default(); clear(); cfg_ftype = 2'd2; cfg_need = 8'd3;
        send(1'b1, 1'b0, 29'h55, 4'd0, 64'h0, p);
        chk("R3 first", p, 1'b0);
        send(1'b1, 1'b0, 29'h56, 4'd4, DGOOD, p);
        chk("R3 mismatch", p, 1'b0);
        good(p);
        chk("R3 second", p, 1'b0);
        chk("R3 flag low before target", wake_flag, 1'b0);
        good(p);
        chk("R3 third", p, 1'b1);
        chk("R13 flag rises", wake_flag, 1'b1);
        @(negedge clk);
        chk("R13 one cycle", wake_pulse, 1'b0);
        good(p);
        chk("R13 no repeat", p, 1'b0);
        chk("R13 flag sticky", wake_flag, 1'b1);
        clear();
        chk("R13 clear flag", wake_flag, 1'b0);
        good(p);
        chk("R13 count restarted", p, 1'b0);

        // R4: full count of two
        cfg_default(); clear(); cfg_ftype = 2'd3; cfg_need = 8'd2;
        send(1'b1, 1'b0, 29'h55, 4'd0, DGOOD, p);
        chk("R4 bad DLC not counted", p, 1'b0);
        good(p);
        chk("R4 first", p, 1'b0);
        good(p);
        chk("R4 second", p, 1'b1);

        // R12: need of zero
        cfg_default(); clear(); cfg_ftype = 2'd2; cfg_need = 8'd0;
        good(p);
        chk("R12 zero acts as one", p, 1'b1);

        repeat (2) @(negedge clk);
        report();
        $finish;
    end
endmodule